// File: doc/BRIEF.md
# Parallel Result Read Formatter

This block drives a stored conversion result onto a tri-state parallel bus when a microprocessor reads it. The bus is modelled as two vectors of equal width: a data vector and a per-line drive enable. A line whose enable is low counts as released. The block decodes a chip-enable, an active-low select, a read/convert strobe, a word-size select and one address bit. From these it chooses one of three formats:

- the whole result word;
- the upper byte, left-justified;
- the lower byte, which carries the remaining low result bits in its top positions and zeros below them.

The bus is released whenever no read is addressed, and also while a conversion is running.

The result is held in an internal register. The register loads from `result_i` on any clock edge where `load_i` is high. Bus data and enables come from flip-flops clocked by the system clock. As a result, the bus never carries a combinational path from a result register that is being written in the same cycle. Every change at the inputs shows at the bus one clock edge after it is sampled.

Top module: `rdbus_fmt`

## Requirements
- R1: While `rst_ni` is low, `bus_oe_o` and `bus_data_o` are all zeros, and the stored result is cleared.
- R2: When `ce_i` is low or `cs_ni` is high at a clock edge, every bus line is released (`bus_oe_o` = 0) after that edge.
- R3: A read is addressed only when `ce_i`=1, `cs_ni`=0 and `rd_i`=1. With `rd_i`=0 the bus is released.
- R4: In an addressed read with `wide_i`=1, all 10 lines are driven (`bus_oe_o`=10'h3FF) with result bits 9..0 on lines 9..0. `addr_i` has no effect in this mode.
- R5: In an addressed read with `wide_i`=0 and `addr_i`=0, lines 9..2 carry result bits 9..2, and `bus_oe_o`=10'h3FC.
- R6: In an addressed read with `wide_i`=0 and `addr_i`=1, lines 9..8 carry result bits 1..0, lines 7..2 are driven to zero, and `bus_oe_o`=10'h3FC.
- R7: While `busy_i`=1, the bus is released regardless of the read controls.
- R8: In both byte modes (`wide_i`=0), lines 1..0 stay released.
- R9: The bus reflects the inputs and stored result sampled at the previous clock edge. A result loaded with `load_i` at one edge reaches the bus after the following edge.
- R10: Any line whose enable is low carries data 0.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load `result_i` into the stored result |
| result_i | input | 10 | New conversion result |
| busy_i | input | 1 | Conversion in progress |
| ce_i | input | 1 | Chip enable, active high |
| cs_ni | input | 1 | Chip select, active low |
| rd_i | input | 1 | Read (1) or convert (0) strobe |
| wide_i | input | 1 | Word-size select: 1 for the full word, 0 for byte mode |
| addr_i | input | 1 | Byte address in byte mode |
| bus_data_o | output | 10 | Parallel bus data |
| bus_oe_o | output | 10 | Per-line drive enable |

## Verification
The assertions assume that every control input is synchronous to `clk_i` and holds steady for at least one edge. They check each bus state one edge after the decoded controls that caused it.

The stimulus changes inputs only on falling edges. It holds each pattern for two rising edges, so the stored result and the registered bus both settle before the bus is sampled. The one exception is the load-latency test, which samples after a single edge on purpose.

// File: rtl/rdbus_pkg.sv
package rdbus_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_WORD = 2'd1,
    DRV_HI   = 2'd2,
    DRV_LO   = 2'd3
  } drv_mode_e;
endpackage

// File: rtl/rdbus_decode.sv
module rdbus_decode
  import rdbus_pkg::*;
(
  input  logic      ce_i,
  input  logic      cs_ni,
  input  logic      rd_i,
  input  logic      busy_i,
  input  logic      wide_i,
  input  logic      addr_i,
  output drv_mode_e mode_o
);
  logic read_hit;
  assign read_hit = ce_i && !cs_ni && rd_i && !busy_i;

  always_comb begin
    if (!read_hit)    mode_o = DRV_OFF;
    else if (wide_i)  mode_o = DRV_WORD;
    else if (!addr_i) mode_o = DRV_HI;
    else              mode_o = DRV_LO;
  end
endmodule

// File: rtl/rdbus_steer.sv
module rdbus_steer
  import rdbus_pkg::*;
#(
  parameter int WIDTH  = 10,
  parameter int BYTE_W = 8
) (
  input  drv_mode_e        mode_i,
  input  logic [WIDTH-1:0] res_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] oe_o
);
  localparam int LOW_W = WIDTH - BYTE_W;  // bits left over for the second byte
  localparam int TOP_B = WIDTH - LOW_W;   // first line carrying them

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    if (i >= TOP_B) begin : g_top
      always_comb begin
        unique case (mode_i)
          DRV_WORD, DRV_HI: begin data_o[i] = res_i[i];         oe_o[i] = 1'b1; end
          DRV_LO:           begin data_o[i] = res_i[i - TOP_B]; oe_o[i] = 1'b1; end
          default:          begin data_o[i] = 1'b0;             oe_o[i] = 1'b0; end
        endcase
      end
    end else if (i >= LOW_W) begin : g_mid
      always_comb begin
        unique case (mode_i)
          DRV_WORD, DRV_HI: begin data_o[i] = res_i[i]; oe_o[i] = 1'b1; end
          DRV_LO:           begin data_o[i] = 1'b0;     oe_o[i] = 1'b1; end  // zero fill
          default:          begin data_o[i] = 1'b0;     oe_o[i] = 1'b0; end
        endcase
      end
    end else begin : g_bot
      always_comb begin
        if (mode_i == DRV_WORD) begin data_o[i] = res_i[i]; oe_o[i] = 1'b1; end
        else                    begin data_o[i] = 1'b0;     oe_o[i] = 1'b0; end
      end
    end
  end
endmodule

// File: rtl/rdbus_fmt.sv
module rdbus_fmt
  import rdbus_pkg::*;
#(
  parameter int WIDTH  = 10,
  parameter int BYTE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             busy_i,
  input  logic             ce_i,
  input  logic             cs_ni,
  input  logic             rd_i,
  input  logic             wide_i,
  input  logic             addr_i,
  output logic [WIDTH-1:0] bus_data_o,
  output logic [WIDTH-1:0] bus_oe_o
);
  localparam int LOW_W = WIDTH - BYTE_W;
  localparam logic [WIDTH-1:0] ALL_ON  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BYTE_ON = {{BYTE_W{1'b1}}, {LOW_W{1'b0}}};

  logic [WIDTH-1:0] res_q, data_d, oe_d;
  drv_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= result_i;
  end

  rdbus_decode u_dec (
    .ce_i(ce_i), .cs_ni(cs_ni), .rd_i(rd_i), .busy_i(busy_i),
    .wide_i(wide_i), .addr_i(addr_i), .mode_o(mode)
  );

  rdbus_steer #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_steer (
    .mode_i(mode), .res_i(res_q), .data_o(data_d), .oe_o(oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_data_o <= '0;
      bus_oe_o   <= '0;
    end else begin
      bus_data_o <= data_d;
      bus_oe_o   <= oe_d;
    end
  end

  logic rd_hit;
  assign rd_hit = ce_i && !cs_ni && rd_i && !busy_i;

  a_r2_not_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i || cs_ni) |=> bus_oe_o == '0);
  a_r3_convert_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> bus_oe_o == '0);
  a_r7_busy_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> bus_oe_o == '0);
  a_r4_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && wide_i) |=> (bus_oe_o == ALL_ON) && (bus_data_o == $past(res_q)));
  a_r5_high_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !wide_i && !addr_i) |=>
      (bus_oe_o == BYTE_ON) && (bus_data_o[WIDTH-1:LOW_W] == $past(res_q[WIDTH-1:LOW_W])));
  a_r6_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !wide_i && addr_i) |=>
      (bus_oe_o == BYTE_ON) && (bus_data_o[WIDTH-1 -: LOW_W] == $past(res_q[LOW_W-1:0]))
      && (bus_data_o[WIDTH-LOW_W-1:LOW_W] == '0));
  a_r8_bottom_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> bus_oe_o[LOW_W-1:0] == '0);
  a_r10_quiet_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_data_o & ~bus_oe_o) == '0);
endmodule

// File: tb/rdbus_fmt_test.sv
module rdbus_fmt_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [9:0] result_i = '0;
  logic       busy_i = 1'b0, ce_i = 1'b0, cs_ni = 1'b1, rd_i = 1'b0;
  logic       wide_i = 1'b0, addr_i = 1'b0;
  logic [9:0] bus_data_o, bus_oe_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  rdbus_fmt uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .result_i(result_i),
    .busy_i(busy_i), .ce_i(ce_i), .cs_ni(cs_ni), .rd_i(rd_i),
    .wide_i(wide_i), .addr_i(addr_i), .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o)
  );

  // {wide,addr,ce,cs_n,rd,busy}, result, expected data, expected enable
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {6'b101010, 10'h2B5, 10'h2B5, 10'h3FF},
    {6'b111010, 10'h2B5, 10'h2B5, 10'h3FF},
    {6'b001010, 10'h2B5, 10'h2B4, 10'h3FC},
    {6'b011010, 10'h2B5, 10'h100, 10'h3FC},
    {6'b011010, 10'h3FF, 10'h300, 10'h3FC},
    {6'b001010, 10'h3FF, 10'h3FC, 10'h3FC},
    {6'b011010, 10'h002, 10'h200, 10'h3FC},
    {6'b100010, 10'h155, 10'h000, 10'h000},
    {6'b101110, 10'h155, 10'h000, 10'h000},
    {6'b101000, 10'h155, 10'h000, 10'h000},
    {6'b101011, 10'h155, 10'h000, 10'h000},
    {6'b011011, 10'h3FF, 10'h000, 10'h000},
    {6'b101010, 10'h000, 10'h000, 10'h3FF}
  };

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    // R1: reset holds the bus quiet while a wide read is requested
    ce_i = 1; cs_ni = 0; rd_i = 1; wide_i = 1; load_i = 1; result_i = 10'h3FF;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 oe", bus_oe_o, 10'h000);
    check("R1 data", bus_data_o, 10'h000);
    load_i = 0;
    rst_ni = 1;
    // R1: stored result cleared by reset
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 cleared result", bus_data_o, 10'h000);

    load_i = 1;
    for (int i = 0; i < NV; i++) begin
      {wide_i, addr_i, ce_i, cs_ni, rd_i, busy_i} = VEC[i][35:30];
      result_i = VEC[i][29:20];
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      if (busy_i)               tag = "R7";
      else if (!ce_i || cs_ni)  tag = "R2";
      else if (!rd_i)           tag = "R3";
      else if (wide_i)          tag = "R4";
      else if (addr_i)          tag = "R6";
      else                      tag = "R5";
      check({tag, " data"}, bus_data_o, VEC[i][19:10]);
      check({tag, " oe"}, bus_oe_o, VEC[i][9:0]);
      check("R10 released lines zero", bus_data_o & ~bus_oe_o, 10'h000);
      if (!wide_i) check("R8 low lines released", {8'h00, bus_oe_o[1:0]}, 10'h000);
    end

    // R9: latency of a new result through the stored register
    {wide_i, addr_i, ce_i, cs_ni, rd_i, busy_i} = 6'b101010;
    result_i = 10'h0F0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    load_i = 1; result_i = 10'h30C;
    @(posedge clk_i);
    @(negedge clk_i);
    load_i = 0;
    check("R9 old value one edge after load", bus_data_o, 10'h0F0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R9 new value two edges after load", bus_data_o, 10'h30C);

    // R9: release one edge after select drops
    cs_ni = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R9 release latency", bus_oe_o, 10'h000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule